// File: doc/BRIEF.md
# Lockable ECC Policy and Correctable-Error Threshold Register

This block is one word of a memory-mapped control space for a nonvolatile-memory error-correction engine. It holds two things. The first is an eight-bit start value for a down-counter of single-bit-corrected error events. The counter is loaded from that value and steps down once per event. An event that arrives after the counter has run out raises a sticky error flag. The second is a two-bit policy field that tells the engine how to treat writes and reads. That field is guarded by a one-way unlock bit. Once software clears the unlock bit, the policy is frozen until the next reset.

Software reaches the word through a simple 32-bit bus made of an address, a write enable, write data, byte strobes and combinational read data. The correction logic drives a one-cycle pulse for every corrected error. A separate clear input drops the sticky flag. The policy field and the flag are presented as outputs to the rest of the engine.

Top module: `ecc_ctl_reg`

## Requirements
- R1: After reset the word at offset 0x20 reads 0x00000040: unlock bit (bit 6) = 1, policy (bits 5:4) = 0, start value (bits 15:8) = 0. The policy output is 0 and the flag output is 0.
- R2: Bits 31:16, 7 and 3:0 always read 0 and ignore writes. Any other address reads 0 and a write to it changes nothing.
- R3: The start value in bits 15:8 can be written and read back at any time, whether the register is locked or not.
- R4: A write to the start value loads the counter. Each event pulse then decrements the counter by one. With start value N, the first N events leave the flag clear and event N+1 sets it.
- R5: The counter stops at zero and never wraps. Every further event at zero keeps setting the flag.
- R6: When a start-value write and an event fall in the same cycle, the write reloads the counter and the event is neither counted nor flagged.
- R7: The flag stays set until the clear input is asserted. If a clear and an event at zero fall in the same cycle, the flag stays set.
- R8: While bit 6 reads 0, writes change neither bit 6 nor the policy field.
- R9: Bit 6 can only be cleared. Writing 1 to it leaves it unchanged whether it is 1 or 0.
- R10: A single write that clears bit 6 and also changes the policy field applies the new policy, because the lock check uses the value of bit 6 from before the write.
- R11: Bits 15:8 are written only when byte strobe 1 is high. Bits 6 and 5:4 are written only when byte strobe 0 is high.
- R12: The policy output equals bits 5:4, using these codes: 0 = corrected writes and checked reads, 1 = dynamic writes and dynamic reads, 2 = corrected writes and dynamic reads, 3 = dynamic writes with unchecked reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sec_evt | input | 1 | One pulse per corrected single-bit error |
| serr_clr | input | 1 | Clears the sticky exhaustion flag |
| ecc_policy | output | 2 | Current policy code |
| serr | output | 1 | Sticky flag for an event that arrives with the counter at zero |

## Verification
Two pairs of actions can fall in the same cycle. A start-value write can coincide with an event pulse, and a flag clear can coincide with an event at zero. The bench drives each pair in one bus cycle. It then counts events from a known start value and uses the number of events needed to raise the flag to tell whether the event was swallowed, counted or flagged. A third case is a single write that clears the unlock bit and sets a new policy at the same time. The bench judges it by reading back the policy and by attempting later writes, which must be ignored.

// File: rtl/ecc_ctl_pkg.sv
package ecc_ctl_pkg;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned STRB_W     = BUS_W / 8;
  localparam int unsigned THR_LSB    = 8;
  localparam int unsigned UNLOCK_BIT = 6;
  localparam int unsigned POL_LSB    = 4;
  localparam int unsigned POL_W      = 2;

  typedef enum logic [POL_W-1:0] {
    POL_STRICT  = 2'd0,
    POL_DYN     = 2'd1,
    POL_ECCW    = 2'd2,
    POL_NOCHECK = 2'd3
  } ecc_policy_e;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_sec_counter.sv
module ecc_sec_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             sec_evt,
  input  logic             serr_clr,
  output logic [CNT_W-1:0] start_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             serr_q
);
  logic [CNT_W-1:0] start_d, cnt_d;
  logic             start_en, cnt_en, serr_d;
  logic             cnt_zero, hit_zero, step;

  always_comb begin
    cnt_zero = (cnt_q == '0);
    step     = sec_evt & ~load & ~cnt_zero;
    hit_zero = sec_evt & ~load & cnt_zero;
    start_en = load;
    start_d  = load_val;
    cnt_en   = load | step;
    cnt_d    = load ? load_val : cnt_q - CNT_W'(1);
    serr_d   = hit_zero | (serr_q & ~serr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      serr_q  <= 1'b0;
    end else begin
      if (start_en) start_q <= start_d;
      if (cnt_en)   cnt_q   <= cnt_d;
      serr_q <= serr_d;
    end
  end
endmodule

// File: rtl/ecc_policy_lock.sv
module ecc_policy_lock
  import ecc_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        unlock_in,
  input  ecc_policy_e pol_in,
  output logic        unlock_q,
  output ecc_policy_e policy_q
);
  logic        upd_en, unlock_d;
  ecc_policy_e policy_d;

  always_comb begin
    upd_en   = wr_en & unlock_q;
    unlock_d = unlock_q & unlock_in;
    policy_d = pol_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlock_q <= 1'b1;
      policy_q <= POL_STRICT;
    end else if (upd_en) begin
      unlock_q <= unlock_d;
      policy_q <= policy_d;
    end
  end
endmodule

// File: rtl/ecc_ctl_reg.sv
module ecc_ctl_reg
  import ecc_ctl_pkg::*;
#(
  parameter int unsigned     ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h20,
  parameter int unsigned     CNT_W       = 8,
  parameter int unsigned     SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic [STRB_W-1:0]   bus_wstrb,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                sec_evt,
  input  logic                serr_clr,
  output logic [POL_W-1:0]    ecc_policy,
  output logic                serr
);
  localparam int unsigned THR_BYTE = THR_LSB / 8;
  localparam int unsigned CTL_BYTE = POL_LSB / 8;

  logic             rst_ns;
  logic             hit, wr_hit, ld_cnt, ld_ctl;
  logic [CNT_W-1:0] ld_val, start_q, cnt_q;
  logic             unlock_q;
  ecc_policy_e      policy_q, pol_in;

  ecc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  always_comb begin
    hit    = (bus_addr == REG_ADDR);
    wr_hit = bus_we & hit;
    ld_cnt = wr_hit & bus_wstrb[THR_BYTE];
    ld_ctl = wr_hit & bus_wstrb[CTL_BYTE];
    ld_val = bus_wdata[THR_LSB +: CNT_W];
    pol_in = ecc_policy_e'(bus_wdata[POL_LSB +: POL_W]);
  end

  ecc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .load(ld_cnt), .load_val(ld_val),
    .sec_evt(sec_evt), .serr_clr(serr_clr),
    .start_q(start_q), .cnt_q(cnt_q), .serr_q(serr)
  );

  ecc_policy_lock u_lock (
    .clk(clk), .rst_n(rst_ns), .wr_en(ld_ctl),
    .unlock_in(bus_wdata[UNLOCK_BIT]), .pol_in(pol_in),
    .unlock_q(unlock_q), .policy_q(policy_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit) begin
      bus_rdata[THR_LSB +: CNT_W] = start_q;
      bus_rdata[UNLOCK_BIT]       = unlock_q;
      bus_rdata[POL_LSB +: POL_W] = policy_q;
    end
  end

  assign ecc_policy = policy_q;
endmodule

// File: rtl/ecc_ctl_reg_chk.sv
module ecc_ctl_reg_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ld_cnt,
  input logic [CNT_W-1:0] ld_val,
  input logic             sec_evt,
  input logic             serr_clr,
  input logic [CNT_W-1:0] cnt,
  input logic             serr,
  input logic             unlock,
  input logic [1:0]       policy
);
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !ld_cnt && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r5_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !ld_cnt) |=> (cnt == '0));

  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ld_cnt |=> (cnt == $past(ld_val)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (serr && !serr_clr) |=> serr);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !ld_cnt && cnt == '0) |=> serr);

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !unlock |=> ($stable(policy) && !unlock));
endmodule

bind ecc_ctl_reg ecc_ctl_reg_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .ld_cnt(ld_cnt), .ld_val(ld_val),
  .sec_evt(sec_evt), .serr_clr(serr_clr), .cnt(cnt_q), .serr(serr),
  .unlock(unlock_q), .policy(policy_q)
);

// File: tb/tb_ecc_ctl_reg.sv
`timescale 1ns/1ps
module tb_ecc_ctl_reg;
  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_wstrb;
  logic [31:0] bus_rdata;
  logic        sec_evt;
  logic        serr_clr;
  logic [1:0]  ecc_policy;
  logic        serr;

  typedef struct {
    int          req;
    int          sel;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  ecc_ctl_reg dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .sec_evt(sec_evt), .serr_clr(serr_clr), .ecc_policy(ecc_policy),
    .serr(serr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [3:0] s, input logic ev, input logic clr);
    @(posedge clk);
    #1;
    bus_we = we; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    sec_evt = ev; serr_clr = clr;
  endtask

  task automatic idle();
    cyc(1'b0, 8'h20, 32'h0, 4'h0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] s);
    cyc(1'b1, 8'h20, d, s, 1'b0, 1'b0);
  endtask

  task automatic ev(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h20, 32'h0, 4'h0, 1'b1, 1'b0);
  endtask

  task automatic expect_item(input int sel, input logic [31:0] e, input int req);
    item_t it;
    it.req = req; it.sel = sel; it.exp = e;
    q.push_back(it);
  endtask

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.sel)
          0:       act = bus_rdata;
          1:       act = {30'b0, ecc_policy};
          default: act = {31'b0, serr};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL R%0d sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_we = 0; bus_addr = 8'h20; bus_wdata = 0; bus_wstrb = 0;
    sec_evt = 0; serr_clr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) idle();

    // R1 reset state
    expect_item(0, 32'h0000_0040, 1);
    expect_item(1, 32'h0, 1);
    expect_item(2, 32'h0, 1);
    idle();

    // R2 reserved bytes: only strobes 3:2
    wr(32'hFFFF_FFFF, 4'b1100);
    idle();
    expect_item(0, 32'h0000_0040, 2);
    // R2 other address reads zero, write there ignored
    cyc(1'b1, 8'h24, 32'hFFFF_FFFF, 4'hF, 1'b0, 1'b0);
    cyc(1'b0, 8'h24, 32'h0, 4'h0, 1'b0, 1'b0);
    expect_item(0, 32'h0, 2);
    idle();
    expect_item(0, 32'h0000_0040, 2);

    // R11 / R3: byte 1 only, byte 0 data (policy 3) ignored
    wr(32'h0000_0530, 4'b0010);
    idle();
    expect_item(0, 32'h0000_0540, 3);
    expect_item(1, 32'h0, 11);

    // R4: start 5, five events clear, sixth flags
    ev(5);
    idle();
    expect_item(2, 32'h0, 4);
    ev(1);
    idle();
    expect_item(2, 32'h1, 4);

    // R7 clear
    cyc(1'b0, 8'h20, 0, 0, 1'b0, 1'b1);
    idle();
    expect_item(2, 32'h0, 7);
    // R5 counter stays at zero: next event flags again
    ev(1);
    idle();
    expect_item(2, 32'h1, 5);
    cyc(1'b0, 8'h20, 0, 0, 1'b0, 1'b1);
    // R7 event at zero together with clear: flag stays
    cyc(1'b0, 8'h20, 0, 0, 1'b1, 1'b1);
    idle();
    expect_item(2, 32'h1, 7);
    cyc(1'b0, 8'h20, 0, 0, 1'b0, 1'b1);
    idle();
    expect_item(2, 32'h0, 7);

    // R6 reload with event in same cycle: load 2, event swallowed
    cyc(1'b1, 8'h20, 32'h0000_0240, 4'b0011, 1'b1, 1'b0);
    idle();
    expect_item(2, 32'h0, 6);
    ev(2);
    idle();
    expect_item(2, 32'h0, 6);
    ev(1);
    idle();
    expect_item(2, 32'h1, 6);
    cyc(1'b0, 8'h20, 0, 0, 1'b0, 1'b1);

    // R12 / R9: each policy code with unlock written 1
    for (int p = 1; p < 4; p++) begin
      wr(32'h0000_0240 | (p << 4), 4'b0001);
      idle();
      expect_item(1, p, 12);
      expect_item(0, 32'h0000_0240 | (p << 4), 9);
    end
    wr(32'h0000_0040, 4'b0001);
    idle();
    expect_item(1, 32'h0, 12);

    // R10: lock and set policy 2 in one write
    wr(32'h0000_0020, 4'b0001);
    idle();
    expect_item(1, 32'h2, 10);
    expect_item(0, 32'h0000_0220, 10);

    // R8 / R9: locked writes ignored
    wr(32'h0000_0070, 4'b0001);
    idle();
    expect_item(1, 32'h2, 8);
    expect_item(0, 32'h0000_0220, 9);
    wr(32'h0000_0000, 4'b0001);
    idle();
    expect_item(1, 32'h2, 8);

    // R3 start value still writable when locked
    wr(32'h0000_AB70, 4'b0011);
    idle();
    expect_item(0, 32'h0000_AB20, 3);

    repeat (3) idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule